// File: doc/BRIEF.md
# DMA Request Enable Register Bank

This block holds one enable bit for each hardware request channel of a descriptor-driven DMA controller. It supports up to 256 channels. Software reaches the bits through a simple register bus made of an address, a write strobe, write data and combinational read data. The bits are packed into eight 32-bit words. The lowest channels sit in the word at byte offset 0x10, and each following word, four bytes higher, holds the next 32 channels.

Each stored bit does two jobs for its channel.

- **Request gating.** It passes or blocks the raw peripheral request on its way to the DMA arbiter.
- **Interrupt steering.** For a channel whose peripheral interrupt is shared with its transfer request, it chooses the source sent to the interrupt controller. A set bit selects the DMA per-channel completion interrupt. A clear bit selects the peripheral's own interrupt.

The parameter `NUM_CH` sets the channel count to 64, 128 or 256. Channels above that count have no storage. They read as zero and ignore writes. Software can change the bits only while the controller reports its normal operating state.

Top module: `dma_req_enable_bank`

## Requirements
- R1: After a synchronous active-low reset every enable bit is 0. All eight words read 0, and `req_gated` is all zero whatever `req_raw` is.
- R2: Word k (k = 0..7) is at byte offset 0x10 + 4k and holds channels 32k+31 down to 32k, with channel 32k in data bit 0. Any write with `ctl_normal` high and `bus_we` high to an implemented word is read back exactly from the next cycle on.
- R3: A write made while `ctl_normal` is low leaves every enable bit unchanged.
- R4: `req_gated` equals `req_raw` AND the stored enable bits, combinationally. A newly written value gates requests from the cycle after the write edge.
- R5: For a channel marked shared in `SHARED_IRQ`, `irq_out` carries `dma_done_irq` when its enable bit is 1 and `periph_irq` when it is 0.
- R6: For a channel not marked shared, `irq_out` always carries `periph_irq`, whatever its enable bit is.
- R7: With `NUM_CH` of 64 or 128, words at and above word `NUM_CH/32` read 0 and ignore writes.
- R8: An offset that is unaligned (low two bits not 00) or outside 0x10..0x2C writes nothing and reads 0.
- R9: Only bus writes change the enable bits. Activity on `req_raw`, `periph_irq` and `dma_done_irq` never alters the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ctl_normal | input | 1 | High while the controller is in its normal state; writes are accepted only then |
| req_raw | input | NUM_CH | Raw peripheral transfer requests |
| req_gated | output | NUM_CH | Requests forwarded to the arbiter |
| periph_irq | input | NUM_CH | Peripheral interrupt lines |
| dma_done_irq | input | NUM_CH | DMA per-channel completion interrupts |
| irq_out | output | NUM_CH | Interrupt lines to the interrupt controller |

## Verification
Each word is written with distinct patterns: walking, alternating and all-ones. Reading every word back tells a correct word mapping apart from swapped or aliased words. The same enable patterns are then combined with all-ones, alternating and sparse request vectors. This separates correct gating from pass-through or inverted gating. The interrupt inputs are driven with complementary values, so each steered line shows which source it took. Writes with the normal state low, writes to unaligned and out-of-range offsets, writes to the unbuilt words of a 64-channel copy, and long input toggling between reads each show whether a bit moved when it should not.

// File: rtl/dreb_pkg.sv
package dreb_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned MAX_CH    = 256;
   localparam int unsigned MAX_WORDS = MAX_CH / WORD_W;
   localparam int unsigned IDX_W     = $clog2(MAX_WORDS);
   localparam int unsigned BASE_OFF  = 32'h10;
   localparam int unsigned LAST_OFF  = BASE_OFF + 4 * (MAX_WORDS - 1);

   function automatic logic ch_count_ok(input int unsigned n);
      return (n == 64) || (n == 128) || (n == 256);
   endfunction
endpackage

// File: rtl/dreb_addr_dec.sv
module dreb_addr_dec
   import dreb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_WORDS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  hit,
   output logic [IDX_W-1:0]      word_idx,
   output logic [MAX_WORDS-1:0]  word_sel
);
   localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(BASE_OFF);
   localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(LAST_OFF);
   localparam logic [IDX_W-1:0]  BASE_W = IDX_W'((BASE_OFF >> 2) % MAX_WORDS);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("dreb_addr_dec: ADDR_W too small for the bank");
   end
   if (NUM_WORDS > MAX_WORDS || NUM_WORDS == 0) begin : g_bad_words
      $error("dreb_addr_dec: NUM_WORDS out of range");
   end

   logic aligned;
   logic in_range;

   always_comb begin
      aligned  = (addr[1:0] == 2'b00);
      in_range = (addr >= LO_A) && (addr <= HI_A);
      hit      = aligned && in_range;
      word_idx = addr[2 +: IDX_W] - BASE_W;
   end

   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_sel
      if (w < NUM_WORDS) begin : g_impl
         assign word_sel[w] = hit && (word_idx == IDX_W'(w));
      end else begin : g_none
         assign word_sel[w] = 1'b0;
      end
   end

   // R2
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(word_sel));
   // R8
   miss_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[1:0] != 2'b00) |-> (word_sel == '0));
endmodule

// File: rtl/dreb_word.sv
module dreb_word #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (wr)
         q <= wdata;
   end

   // R2
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == $past(wdata)));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));
endmodule

// File: rtl/dreb_route.sv
module dreb_route #(
   parameter int unsigned        NUM_CH = 256,
   parameter logic [NUM_CH-1:0]  SHARED = '1
) (
   input  logic [NUM_CH-1:0] en,
   input  logic [NUM_CH-1:0] req_raw,
   input  logic [NUM_CH-1:0] periph_irq,
   input  logic [NUM_CH-1:0] dma_done_irq,
   output logic [NUM_CH-1:0] req_gated,
   output logic [NUM_CH-1:0] irq_out
);
   assign req_gated = req_raw & en;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      if (SHARED[i]) begin : g_steer
         assign irq_out[i] = en[i] ? dma_done_irq[i] : periph_irq[i];
      end else begin : g_direct
         assign irq_out[i] = periph_irq[i];
      end
   end
endmodule

// File: rtl/dma_req_enable_bank.sv
module dma_req_enable_bank
   import dreb_pkg::*;
#(
   parameter int unsigned         NUM_CH     = 256,
   parameter int unsigned         ADDR_W     = 8,
   parameter logic [MAX_CH-1:0]   SHARED_IRQ = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ctl_normal,
   input  logic [NUM_CH-1:0] req_raw,
   output logic [NUM_CH-1:0] req_gated,
   input  logic [NUM_CH-1:0] periph_irq,
   input  logic [NUM_CH-1:0] dma_done_irq,
   output logic [NUM_CH-1:0] irq_out
);
   localparam int unsigned NUM_WORDS = NUM_CH / WORD_W;

   if (!ch_count_ok(NUM_CH)) begin : g_bad_ch
      $error("dma_req_enable_bank: NUM_CH must be 64, 128 or 256");
   end

   logic                  hit;
   logic [IDX_W-1:0]      word_idx;
   logic [MAX_WORDS-1:0]  word_sel;
   logic [WORD_W-1:0]     word_q [MAX_WORDS];
   logic [MAX_CH-1:0]     en_all;
   logic [NUM_CH-1:0]     en;

   dreb_addr_dec #(
      .ADDR_W    (ADDR_W),
      .NUM_WORDS (NUM_WORDS)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .hit      (hit),
      .word_idx (word_idx),
      .word_sel (word_sel)
   );

   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
      if (w < NUM_WORDS) begin : g_impl
         logic wr_w;
         assign wr_w = bus_we && ctl_normal && word_sel[w];
         dreb_word #(.W(WORD_W)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_w),
            .wdata (bus_wdata),
            .q     (word_q[w])
         );
      end else begin : g_tied
         assign word_q[w] = '0;
      end
      assign en_all[w*WORD_W +: WORD_W] = word_q[w];
   end

   assign en        = en_all[NUM_CH-1:0];
   assign bus_rdata = hit ? word_q[word_idx] : '0;

   dreb_route #(
      .NUM_CH (NUM_CH),
      .SHARED (SHARED_IRQ[NUM_CH-1:0])
   ) u_route (
      .en           (en),
      .req_raw      (req_raw),
      .periph_irq   (periph_irq),
      .dma_done_irq (dma_done_irq),
      .req_gated    (req_gated),
      .irq_out      (irq_out)
   );

   // R3
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_normal |=> $stable(en));
   // R4
   gate_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_gated & ~en) == '0);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (en == '0));
endmodule

// File: tb/dma_req_enable_bank_test.sv
module dma_req_enable_bank_test;
   typedef struct {
      int          kind;
      logic [255:0] exp;
      string       tag;
   } item_t;

   item_t sbq[$];
   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic         clk = 0;
   logic         rst_n = 0;
   logic [7:0]   addr = 8'h10;
   logic         we = 0;
   logic [31:0]  wdata = '0;
   logic         normal = 1;
   logic [255:0] req = '0, pirq = '0, dirq = '0;
   logic [31:0]  rdata, rdata_s;
   logic [255:0] gated, irq;
   logic [63:0]  gated_s, irq_s;
   logic [255:0] m_en = '0;
   logic [63:0]  m_en_s = '0;

   always #5 clk = ~clk;

   dma_req_enable_bank uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rdata), .ctl_normal(normal), .req_raw(req), .req_gated(gated),
      .periph_irq(pirq), .dma_done_irq(dirq), .irq_out(irq));

   dma_req_enable_bank #(.NUM_CH(64), .SHARED_IRQ(~256'h1)) uut_small (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rdata_s), .ctl_normal(normal), .req_raw(req[63:0]),
      .req_gated(gated_s), .periph_irq(pirq[63:0]), .dma_done_irq(dirq[63:0]),
      .irq_out(irq_s));

   function automatic logic valid_off(input logic [7:0] a);
      return a[1:0] == 2'b00 && a >= 8'h10 && a <= 8'h2C;
   endfunction

   function automatic int off_idx(input logic [7:0] a);
      return (int'(a) - 16) / 4;
   endfunction

   // monitor: pops expected items and compares against the outputs
   always @(negedge clk) begin
      while (sbq.size() > 0) begin
         item_t it;
         logic [255:0] act;
         it = sbq.pop_front();
         case (it.kind)
            0: act = {224'd0, rdata};
            1: act = {224'd0, rdata_s};
            2: act = gated;
            3: act = {192'd0, gated_s};
            4: act = irq;
            default: act = {192'd0, irq_s};
         endcase
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
         end
      end
   end

   task automatic push(input int k, input logic [255:0] e, input string t);
      item_t it;
      it.kind = k; it.exp = e; it.tag = t;
      sbq.push_back(it);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic nrm);
      @(posedge clk); #1;
      addr = a; wdata = d; we = 1; normal = nrm;
      @(posedge clk); #1;
      we = 0; normal = 1;
      if (nrm && valid_off(a)) begin
         m_en[off_idx(a)*32 +: 32] = d;
         if (off_idx(a) < 2) m_en_s[off_idx(a)*32 +: 32] = d;
      end
   endtask

   task automatic rd(input logic [7:0] a, input string t);
      logic [31:0] e, es;
      @(posedge clk); #1;
      addr = a;
      e  = valid_off(a) ? m_en[off_idx(a)*32 +: 32] : 32'd0;
      es = (valid_off(a) && off_idx(a) < 2) ? m_en_s[off_idx(a)*32 +: 32] : 32'd0;
      push(0, {224'd0, e}, t);
      push(1, {224'd0, es}, t);
      @(negedge clk); #1;
   endtask

   task automatic route(input string t);
      logic [255:0] ei;
      logic [63:0]  eis;
      ei  = (m_en & dirq) | (~m_en & pirq);
      eis = (m_en_s & dirq[63:0]) | (~m_en_s & pirq[63:0]);
      eis[0] = pirq[0];
      push(2, req & m_en, {t, " gate"});
      push(3, {192'd0, req[63:0] & m_en_s}, {t, " gate64"});
      push(4, ei, {t, " irq"});
      push(5, {192'd0, eis}, {t, " irq64"});
      @(negedge clk); #1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      req = '1; pirq = '1; dirq = '0;
      for (int k = 0; k < 8; k++) rd(8'h10 + 8'(4*k), "R1 reset read");
      route("R1 reset");
      // R2: word mapping with distinct patterns
      for (int k = 0; k < 8; k++) wr(8'h10 + 8'(4*k), 32'h0101_0000 * (k + 1) ^ (32'h1 << (k * 3)), 1);
      for (int k = 0; k < 8; k++) rd(8'h10 + 8'(4*k), "R2 readback");
      wr(8'h1C, 32'hFFFF_FFFF, 1);
      wr(8'h10, 32'hAAAA_5555, 1);
      rd(8'h1C, "R2 all ones");
      rd(8'h10, "R2 alternating");
      // R3: writes outside the normal state
      wr(8'h14, 32'h1234_5678, 0);
      wr(8'h2C, 32'h0, 0);
      rd(8'h14, "R3 blocked write");
      rd(8'h2C, "R3 blocked write");
      // R4: gating effective the cycle after the write
      req = '1;
      wr(8'h18, 32'h0000_00F0, 1);
      route("R4 after write");
      req = {64{4'b0101}};
      route("R4 alternating req");
      req = 256'h1 | (256'h1 << 77) | (256'h1 << 255);
      route("R4 sparse req");
      // R5 / R6: interrupt steering with complementary sources
      pirq = {64{4'hA}}; dirq = ~pirq;
      route("R5 steer");
      wr(8'h10, 32'h0000_0001, 1);
      route("R6 unshared bit0 enabled");
      wr(8'h10, 32'h0000_0000, 1);
      route("R6 unshared bit0 disabled");
      // R7: unbuilt words of the 64-channel copy
      wr(8'h18, 32'hDEAD_BEEF, 1);
      wr(8'h2C, 32'hCAFE_F00D, 1);
      rd(8'h18, "R7 upper word");
      rd(8'h2C, "R7 top word");
      rd(8'h14, "R7 implemented word");
      // R8: bad offsets
      wr(8'h11, 32'hFFFF_FFFF, 1);
      wr(8'h30, 32'hFFFF_FFFF, 1);
      wr(8'h0C, 32'hFFFF_FFFF, 1);
      rd(8'h11, "R8 unaligned read");
      rd(8'h30, "R8 above range read");
      rd(8'h0C, "R8 below range read");
      rd(8'h10, "R8 neighbour intact");
      rd(8'h2C, "R8 neighbour intact");
      // R9: input activity does not change the bits
      for (int c = 0; c < 50; c++) begin
         @(posedge clk); #1;
         req = ~req; pirq = ~pirq; dirq = {dirq[254:0], dirq[255]};
      end
      for (int k = 0; k < 8; k++) rd(8'h10 + 8'(4*k), "R9 unchanged");
      route("R9 route");
      // R1: reset again clears everything
      @(posedge clk); #1 rst_n = 0;
      @(posedge clk); #1 rst_n = 1;
      m_en = '0; m_en_s = '0;
      rd(8'h1C, "R1 second reset");
      route("R1 second reset");
      repeat (2) @(posedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule